// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a field-configurable two-level logic array. An AND plane builds product terms from the true and complemented forms of the array inputs, and an OR plane merges those terms into the outputs. One product term can feed any number of outputs, so a term that several functions need is built once and shared. The path from `x_in` to `f_out` is purely combinational.

The personality is loaded one bit per clock through a serial chain into a shadow store, while the running logic keeps using the previous personality. A one-cycle `cfg_done` pulse then copies the shadow store into the active store. The `pal_mode` input selects one of two OR-plane behaviours. When it is low, the OR plane is fully programmable. When it is high, each output is the fixed OR of its own group of four product terms, and the programmed OR bits are not used.

Top module: `sop_array`

## Requirements
- R1: Each (term, input) pair holds a 2-bit literal code: bit 0 set requires the input to be 1, bit 1 set requires it to be 0, and code 00 makes the term independent of that input.
- R2: A literal code of 11 forces its product term to 0 for every input value.
- R3: A product term with every literal code at 00 evaluates to 1. In programmable-OR mode, an output with no connected term evaluates to 0.
- R4: With `pal_mode` low, output o is the OR of every term t whose OR bit (t, o) is 1. One term may drive several outputs.
- R5: With `pal_mode` high, output o is the OR of terms 4*o to 4*o+3, and all OR-plane bits are ignored.
- R6: The k-th bit shifted in lands at chain index k. The literal code of term t, input i occupies indices 2*(t*N_IN+i) (bit 0) and 2*(t*N_IN+i)+1 (bit 1). OR bit (t, o) sits at index N_TERM*N_IN*2 + t*N_OUT + o.
- R7: Shifting with `cfg_en` leaves `f_out` unchanged. The shadow contents drive `f_out` only from the clock edge at which `cfg_done` is sampled high.
- R8: A synchronous active-low reset clears the shadow store and the active store. After reset, `f_out` is all zeros with `pal_mode` low and all ones with `pal_mode` high.
- R9: `f_out` follows changes on `x_in` and `pal_mode` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration stores |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Shift one configuration bit in on this edge |
| cfg_data | input | 1 | Serial configuration bit |
| cfg_done | input | 1 | Copy the shadow store into the active store |
| pal_mode | input | 1 | 1 = fixed four-term groups per output, 0 = programmable OR plane |
| x_in | input | N_IN | Logic inputs |
| f_out | output | N_OUT | Logic outputs |

## Verification
The logic results (R1 to R5, R9) are due in the same cycle as the input change. The bench drives `x_in` and `pal_mode` just after a falling edge and samples `f_out` 1 ns later, before any rising edge. A new personality is due right after the rising edge that samples `cfg_done`. The bench therefore samples once before that edge, where the old outputs must still hold, and once after it, where the new outputs must appear. Reset effects are sampled after the first edge at which `rst_n` is low.

// File: rtl/sop_pkg.sv
// Package: shared literal encoding and configuration-chain index helpers
// for the sum-of-products array. Assumes the chain layout stated in R6.
package sop_pkg;

    // Literal condition per (term, input): bit0 = need-true, bit1 = need-false.
    typedef enum logic [1:0] {
        LIT_OFF  = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_COMP = 2'b10,
        LIT_KILL = 2'b11
    } lit_code_t;

    // Chain index of the low bit of the literal code for term t, input i.
    function automatic int and_bit(input int t, input int i, input int n_in);
        return (t * n_in + i) * 2;
    endfunction

    // Index of OR bit (t, o) inside the OR-plane slice.
    function automatic int or_bit(input int t, input int o, input int n_out);
        return t * n_out + o;
    endfunction

    // First term of the fixed group that belongs to output o.
    function automatic int grp_base(input int o, input int tpo, input int n_term);
        return (o * tpo) % n_term;
    endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
// Module: serial configuration store. It shifts bits into a shadow register
// and copies the shadow register into an active register on cfg_done.
// Assumes cfg_en and cfg_done come from synchronous logic on clk. If both are
// high on one edge, the copy takes the shadow contents from before the shift.
module sop_cfg_chain #(
    parameter int WIDTH = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_data,
    input  logic             cfg_done,
    output logic [WIDTH-1:0] active_q
);

    logic [WIDTH-1:0] shadow_q;

    // Shadow store: each new bit enters at the top and moves down one place
    // per shift, so the first bit sent ends at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (cfg_en) begin
            shadow_q <= {cfg_data, shadow_q[WIDTH-1:1]};
        end
    end

    // Active store: takes the whole shadow image in one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (cfg_done) begin
            active_q <= shadow_q;
        end
    end

endmodule

// File: rtl/sop_and_plane.sv
// Module: programmable AND plane. Each product term is the AND of one
// qualifier per input, decoded from a 2-bit literal code.
// Assumes the literal layout given by sop_pkg::and_bit.
module sop_and_plane
    import sop_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_TERM = 16,
    localparam int AND_BITS = N_TERM * N_IN * 2
) (
    input  logic [N_IN-1:0]     x_in,
    input  logic [AND_BITS-1:0] and_cfg,
    output logic [N_TERM-1:0]   term_vec
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_IN-1:0] lit_ok;

        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            localparam int LO = and_bit(t, i, N_IN);
            lit_code_t code;
            assign code = lit_code_t'(and_cfg[LO +: 2]);

            // Qualifier: 1 when this input satisfies the literal condition.
            always_comb begin
                unique case (code)
                    LIT_OFF:  lit_ok[i] = 1'b1;
                    LIT_TRUE: lit_ok[i] = x_in[i];
                    LIT_COMP: lit_ok[i] = ~x_in[i];
                    default:  lit_ok[i] = 1'b0;
                endcase
            end
        end

        // Term value: all qualifiers met (an empty term gives 1).
        assign term_vec[t] = &lit_ok;
    end

endmodule

// File: rtl/sop_or_plane.sv
// Module: OR plane with two variants chosen at run time. The programmable
// variant ORs every connected term. The fixed variant ORs a group of TPO
// terms that belongs to each output. Assumes N_TERM >= TPO; when
// N_OUT*TPO > N_TERM the groups wrap around and overlap.
module sop_or_plane
    import sop_pkg::*;
#(
    parameter int N_TERM = 16,
    parameter int N_OUT  = 4,
    parameter int TPO    = 4,
    localparam int OR_BITS = N_TERM * N_OUT
) (
    input  logic [N_TERM-1:0]  term_vec,
    input  logic [OR_BITS-1:0] or_cfg,
    input  logic               pal_mode,
    output logic [N_OUT-1:0]   f_out
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam int BASE = grp_base(o, TPO, N_TERM);
        logic [N_TERM-1:0] conn;
        logic [TPO-1:0]    grp;
        logic              prog_or;
        logic              fixed_or;

        // Connection mask: the OR-plane column for this output.
        always_comb begin
            for (int t = 0; t < N_TERM; t++) begin
                conn[t] = or_cfg[or_bit(t, o, N_OUT)];
            end
        end

        // Fixed group: gather this output's own TPO terms.
        always_comb begin
            for (int k = 0; k < TPO; k++) begin
                grp[k] = term_vec[(BASE + k) % N_TERM];
            end
        end

        assign prog_or  = |(term_vec & conn);
        assign fixed_or = |grp;

        // Variant select: fixed groups when pal_mode is high.
        always_comb begin
            f_out[o] = pal_mode ? fixed_or : prog_or;
        end
    end

endmodule

// File: rtl/sop_array.sv
// Module: top of the configurable sum-of-products array. It wires the
// serial configuration store to the AND plane and the OR plane.
// Assumes the configuration is loaded while the logic results are not used.
// The outputs are combinational from x_in and pal_mode.
module sop_array
    import sop_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_TERM = 16,
    parameter int N_OUT  = 4,
    parameter int TPO    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_data,
    input  logic             cfg_done,
    input  logic             pal_mode,
    input  logic [N_IN-1:0]  x_in,
    output logic [N_OUT-1:0] f_out
);

    localparam int AND_BITS = N_TERM * N_IN * 2;
    localparam int OR_BITS  = N_TERM * N_OUT;
    localparam int CFG_BITS = AND_BITS + OR_BITS;

    logic [CFG_BITS-1:0] cfg_active;
    logic [AND_BITS-1:0] and_cfg;
    logic [OR_BITS-1:0]  or_cfg;
    logic [N_TERM-1:0]   term_vec;

    assign and_cfg = cfg_active[AND_BITS-1:0];
    assign or_cfg  = cfg_active[CFG_BITS-1:AND_BITS];

    sop_cfg_chain #(
        .WIDTH (CFG_BITS)
    ) chain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_data (cfg_data),
        .cfg_done (cfg_done),
        .active_q (cfg_active)
    );

    sop_and_plane #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM)
    ) and_i (
        .x_in     (x_in),
        .and_cfg  (and_cfg),
        .term_vec (term_vec)
    );

    sop_or_plane #(
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT),
        .TPO    (TPO)
    ) or_i (
        .term_vec (term_vec),
        .or_cfg   (or_cfg),
        .pal_mode (pal_mode),
        .f_out    (f_out)
    );

endmodule

// File: rtl/sop_array_chk.sv
// Module: assertion checker for sop_array, attached by bind. It relates the
// active configuration, the AND-plane terms and the outputs over time.
module sop_array_chk
    import sop_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_TERM = 16,
    parameter int N_OUT  = 4,
    parameter int TPO    = 4,
    localparam int AND_BITS = N_TERM * N_IN * 2,
    localparam int OR_BITS  = N_TERM * N_OUT
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_done,
    input logic                pal_mode,
    input logic [N_IN-1:0]     x_in,
    input logic [N_OUT-1:0]    f_out,
    input logic [AND_BITS-1:0] and_cfg,
    input logic [OR_BITS-1:0]  or_cfg,
    input logic [N_TERM-1:0]   term_vec
);

    // Outputs hold across a cycle that has no copy and no input change.
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> (!$stable(x_in) || !$stable(pal_mode) || $stable(f_out))); // R7

    // The first cycle after reset shows the cleared personality.
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !pal_mode) |-> (f_out == '0)); // R8

    for (genvar t = 0; t < N_TERM; t++) begin : g_t
        localparam int LO = and_bit(t, 0, N_IN);

        // A term with no literals enabled must be 1.
        AST_EMPTY_TERM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (and_cfg[LO +: 2*N_IN] == '0) |-> term_vec[t]); // R3

        for (genvar i = 0; i < N_IN; i++) begin : g_i
            localparam int LB = and_bit(t, i, N_IN);
            // Both literal bits set kills the term.
            AST_KILL_TERM: assert property (@(posedge clk) disable iff (!rst_n)
                (and_cfg[LB] && and_cfg[LB+1]) |-> !term_vec[t]); // R2
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_o
        localparam int BASE = grp_base(o, TPO, N_TERM);
        logic [N_TERM-1:0] col;
        logic [TPO-1:0]    grp;

        always_comb begin
            for (int t = 0; t < N_TERM; t++) col[t] = or_cfg[or_bit(t, o, N_OUT)];
            for (int k = 0; k < TPO; k++)    grp[k] = term_vec[(BASE + k) % N_TERM];
        end

        // Programmable mode: an unconnected output is 0.
        AST_EMPTY_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (!pal_mode && col == '0) |-> !f_out[o]); // R3

        // Fixed mode: the output follows only its own term group.
        AST_PAL_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
            pal_mode |-> (f_out[o] == (|grp))); // R5
    end

endmodule

bind sop_array sop_array_chk #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT),
    .TPO    (TPO)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_done (cfg_done),
    .pal_mode (pal_mode),
    .x_in     (x_in),
    .f_out    (f_out),
    .and_cfg  (and_cfg),
    .or_cfg   (or_cfg),
    .term_vec (term_vec)
);

// File: tb/sop_array_tb.sv
// Bench for sop_array. A vector table is walked in both OR-plane modes,
// followed by directed tests for reset, load timing and literal corner cases.
module sop_array_tb_top;

    localparam int N_IN   = 4;
    localparam int N_TERM = 16;
    localparam int N_OUT  = 4;
    localparam int TPO    = 4;
    localparam int AND_BITS = N_TERM * N_IN * 2;
    localparam int CFG_BITS = AND_BITS + N_TERM * N_OUT;

    // {A,B,C} then expected {F3,F2,F1,F0}; A=x[2], B=x[1], C=x[0], x[3] unused.
    localparam logic [6:0] VEC [8] = '{
        {3'b000, 4'b0101}, {3'b001, 4'b1000}, {3'b010, 4'b0000}, {3'b011, 4'b0000},
        {3'b100, 4'b1111}, {3'b101, 4'b1001}, {3'b110, 4'b1111}, {3'b111, 4'b1111}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic cfg_data = 1'b0;
    logic cfg_done = 1'b0;
    logic pal_mode = 1'b0;
    logic [N_IN-1:0]  x_in = '0;
    logic [N_OUT-1:0] f_out;

    int checks = 0;
    int failures = 0;

    logic [1:0] lit_q [N_TERM][N_IN];
    logic       orb_q [N_TERM][N_OUT];

    always #2.5 clk = ~clk;

    sop_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .TPO(TPO)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_data(cfg_data),
        .cfg_done(cfg_done), .pal_mode(pal_mode), .x_in(x_in), .f_out(f_out)
    );

    task automatic check(input string req, input logic [N_OUT-1:0] exp);
        checks++;
        if (f_out !== exp) begin
            failures++;
            $display("FAIL %s x=%b pal=%b actual=%b expected=%b", req, x_in, pal_mode, f_out, exp);
        end
    endtask

    task automatic clear_pers();
        for (int t = 0; t < N_TERM; t++)
            for (int k = 0; k < N_IN; k++) lit_q[t][k] = 2'b00;
        for (int t = 0; t < N_TERM; t++)
            for (int o = 0; o < N_OUT; o++) orb_q[t][o] = 1'b0;
    endtask

    // Shift the image (R6 layout) without applying it.
    task automatic shift_pers();
        logic [CFG_BITS-1:0] img;
        for (int t = 0; t < N_TERM; t++) begin
            for (int k = 0; k < N_IN; k++) img[(t*N_IN+k)*2 +: 2] = lit_q[t][k];
            for (int o = 0; o < N_OUT; o++) img[AND_BITS + t*N_OUT + o] = orb_q[t][o];
        end
        for (int b = 0; b < CFG_BITS; b++) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_data = img[b];
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic apply_pers();
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
    endtask

    task automatic set_x(input logic [N_IN-1:0] v);
        x_in = v;
        #1;
    endtask

    task automatic walk_table(input string req);
        for (int d = 0; d < 2; d++)
            for (int r = 0; r < 8; r++) begin
                @(negedge clk);
                set_x({d[0], VEC[r][6:4]});
                check(req, VEC[r][3:0]);
            end
    endtask

    initial begin : watchdog
        #400000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R8: cleared personality in both modes (empty terms give 1, R3).
        set_x(4'b0101);
        check("R8 reset pla", 4'b0000);
        pal_mode = 1'b1; #1;
        check("R8 reset pal / R3 empty term", 4'b1111);
        pal_mode = 1'b0; #1;
        rst_n = 1'b1;

        // Example personality in programmable-OR mode.
        clear_pers();
        lit_q[0][2] = 2'b01; lit_q[0][1] = 2'b01;              // AB
        lit_q[1][1] = 2'b10; lit_q[1][0] = 2'b10;              // B'C'
        lit_q[2][2] = 2'b01; lit_q[2][0] = 2'b10;              // AC'
        lit_q[3][1] = 2'b10; lit_q[3][0] = 2'b01;              // B'C
        lit_q[4][2] = 2'b01;                                   // A
        orb_q[4][0] = 1; orb_q[1][0] = 1;
        orb_q[2][1] = 1; orb_q[0][1] = 1;
        orb_q[1][2] = 1; orb_q[0][2] = 1;
        orb_q[3][3] = 1; orb_q[4][3] = 1;
        set_x(4'b0100);
        shift_pers();
        check("R7 hold after shift", 4'b0000);
        apply_pers();
        check("R7 applied after done", 4'b1111);
        walk_table("R1/R4 pla table");

        // R9: an input change without a clock edge shows at once.
        @(posedge clk); #1;
        set_x(4'b0000);
        check("R9 no-edge response", 4'b0101);
        set_x(4'b0001);
        check("R9 no-edge response", 4'b1000);

        // Fixed-group personality; OR bits all ones must be ignored (R5).
        clear_pers();
        for (int t = 0; t < N_TERM; t++) begin
            lit_q[t][3] = 2'b11;
            for (int o = 0; o < N_OUT; o++) orb_q[t][o] = 1'b1;
        end
        lit_q[0][3]  = 2'b00; lit_q[0][2] = 2'b01;                            // A
        lit_q[1][3]  = 2'b00; lit_q[1][1] = 2'b10; lit_q[1][0] = 2'b10;       // B'C'
        lit_q[4][3]  = 2'b00; lit_q[4][2] = 2'b01; lit_q[4][0] = 2'b10;       // AC'
        lit_q[5][3]  = 2'b00; lit_q[5][2] = 2'b01; lit_q[5][1] = 2'b01;       // AB
        lit_q[8][3]  = 2'b00; lit_q[8][1] = 2'b10; lit_q[8][0] = 2'b10;       // B'C'
        lit_q[9][3]  = 2'b00; lit_q[9][2] = 2'b01; lit_q[9][1] = 2'b01;       // AB
        lit_q[12][3] = 2'b00; lit_q[12][1] = 2'b10; lit_q[12][0] = 2'b01;     // B'C
        lit_q[13][3] = 2'b00; lit_q[13][2] = 2'b01;                           // A
        shift_pers();
        apply_pers();
        pal_mode = 1'b1;
        walk_table("R5 pal table / R2 killed fillers");

        // R2/R3/R6: kill term, empty term, isolated index placement.
        pal_mode = 1'b0;
        clear_pers();
        lit_q[0][2] = 2'b11; orb_q[0][0] = 1;     // killed term -> F0
        orb_q[1][1] = 1;                          // empty term -> F1
        lit_q[2][3] = 2'b01; orb_q[2][3] = 1;     // D only (index 22, OR index 139) -> F3
        shift_pers();
        apply_pers();
        set_x(4'b1111);
        check("R2/R3/R6 corner x=F", 4'b1010);
        set_x(4'b0000);
        check("R2/R3/R6 corner x=0", 4'b0010);

        // R8: reset in mid-run clears the active store.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        set_x(4'b1111);
        check("R8 mid-run reset", 4'b0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule